// File: doc/BRIEF.md
# Two-Thread Store Buffer with Same-Thread Forwarding

This block holds stores for a core that runs two hardware threads, from the time a store issues until it is written to the data cache. Each thread owns a fixed share of the entries, kept as a ring in program order. An entry is claimed at issue. Its address and its data arrive later, in either order. The entry is marked retired once its store is no longer speculative. Retired entries leave through a commit port in program order, and the entry is freed at that point.

Loads check the buffer of their own thread through a combinational lookup. A load is taken to be younger than every store of its thread that is still held. The youngest store with an equal full address supplies the data. If the answer cannot be trusted yet, the load is told to replay. A thread never sees a store of its sibling until that store has reached the cache.

The commit port is valid/ready. The payload is offered while `cm_valid` is high. It is consumed on a rising edge where `cm_ready` is also high. While `cm_ready` is low, the offered store and its thread stay fixed. The allocate port is also valid/ready: `alloc_ready` for the thread named on `alloc_tid` depends only on that thread's fill state and on a flush of that thread in the same cycle. The address-write, data-write, retire, flush and lookup pins are plain strobes.

Top module: `store_buffer_2t`

## Requirements
- R1: After reset, `cm_valid` is low, `alloc_ready` is high for both threads, and a lookup returns neither hit nor replay.
- R2: Each thread accepts `N_PER_THR` allocations. After that, `alloc_ready` for that thread is low until one of its entries commits, while the other thread still accepts allocations.
- R3: The address and the data of an entry may be written in either order. A retire is only issued for an entry whose address and data are both written, and the commit carries both values.
- R4: An entry that has not retired never appears on the commit port.
- R5: Each thread's entries commit in program order, at most one entry per cycle across both threads. The slot is freed at commit, so the thread can allocate again.
- R6: A lookup hits on the youngest held store of the same thread whose full address equals the load address, and returns that store's data.
- R7: A lookup never hits on an entry of the other thread.
- R8: A lookup raises `ld_replay` instead of `ld_hit` in two cases: some held store of its thread still has no address, or the youngest matching store has no data yet.
- R9: A flush of a thread removes all of that thread's unretired entries. Its retired entries still commit, and the other thread is untouched.
- R10: When both threads have a retired head, the commits alternate between them. After reset, thread 0 goes first.
- R11: While `cm_valid` is high and `cm_ready` is low, `cm_tid`, `cm_addr` and `cm_data` hold their values in the next cycle.
- R12: A retire and a flush of the same thread in the same cycle act in that order, so the store that retires survives the flush.
- R13: Slot numbers returned on `alloc_slot` count up from 0 after reset, modulo `N_PER_THR`, independently per thread. A flush rewinds the next slot to just past the last retired entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to claim an entry |
| alloc_tid | input | 1 | Thread of the allocation |
| alloc_ready | output | 1 | Thread named by `alloc_tid` can take an entry |
| alloc_slot | output | IW | Slot number given to the allocation |
| aw_valid | input | 1 | Address write strobe |
| aw_tid | input | 1 | Thread of the address write |
| aw_slot | input | IW | Slot receiving the address |
| aw_addr | input | ADDR_W | Store address |
| dw_valid | input | 1 | Data write strobe |
| dw_tid | input | 1 | Thread of the data write |
| dw_slot | input | IW | Slot receiving the data |
| dw_data | input | DATA_W | Store data |
| retire_valid | input | 1 | Oldest unretired store of `retire_tid` retires |
| retire_tid | input | 1 | Thread of the retire |
| flush_valid | input | 1 | Drop unretired stores of `flush_tid` |
| flush_tid | input | 1 | Thread of the flush |
| ld_valid | input | 1 | Load lookup strobe |
| ld_tid | input | 1 | Thread of the load |
| ld_addr | input | ADDR_W | Load address |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_replay | output | 1 | Load must retry later |
| ld_data | output | DATA_W | Forwarded data |
| cm_valid | output | 1 | A retired store is offered to the cache |
| cm_ready | input | 1 | Cache accepts the offered store |
| cm_tid | output | 1 | Thread of the offered store |
| cm_addr | output | ADDR_W | Address of the offered store |
| cm_data | output | DATA_W | Data of the offered store |

## Verification
Retire and flush of the same thread can land in one cycle. The bench provokes this on a thread that holds two unretired stores. It then judges, through the commit scoreboard, that the older store still reaches the cache and that the younger one never does. It also checks that a lookup of the dropped store's address then misses. A second pairing is a new retire on the idle thread while the commit port is stalled. Here the bench requires the offered thread not to change until the stalled store is taken.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int NUM_THR = 2;
  typedef logic thr_t;
endpackage

// File: rtl/sb_thread_part.sv
`timescale 1ns/1ps
module sb_thread_part #(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(N),
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_go,
  input  logic              aw_go,
  input  logic [IW-1:0]     aw_idx,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              dw_go,
  input  logic [IW-1:0]     dw_idx,
  input  logic [DATA_W-1:0] dw_data,
  input  logic              retire_go,
  input  logic              flush_go,
  input  logic              take,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              full,
  output logic [IW-1:0]     tail_idx,
  output logic              head_rdy,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              lk_hit,
  output logic              lk_replay,
  output logic [DATA_W-1:0] lk_data
);
  logic [IW-1:0]     head_q, tail_q;
  logic [CW-1:0]     cnt_q, rcnt_q;
  logic [N-1:0]      a_ok_q, d_ok_q;
  logic [ADDR_W-1:0] addr_q [N];
  logic [DATA_W-1:0] data_q [N];

  logic              ret_ok;
  logic [IW-1:0]     rslot, head_n, aw_off, dw_off;
  logic [CW-1:0]     rc_n;
  logic              aw_live, dw_live;

  assign aw_off  = aw_idx - head_q;
  assign dw_off  = dw_idx - head_q;
  assign aw_live = aw_go && ({1'b0, aw_off} < cnt_q);
  assign dw_live = dw_go && ({1'b0, dw_off} < cnt_q);

  assign rslot   = head_q + rcnt_q[IW-1:0];
  assign ret_ok  = retire_go && (rcnt_q < cnt_q);
  assign rc_n    = rcnt_q + CW'(ret_ok) - CW'(take);
  assign head_n  = head_q + IW'(take);

  assign full      = (cnt_q == CW'(N));
  assign tail_idx  = tail_q;
  assign head_rdy  = (rcnt_q != '0);
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

  // ring pointers and counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      rcnt_q <= '0;
    end else begin
      head_q <= head_n;
      rcnt_q <= rc_n;
      if (flush_go) begin
        cnt_q  <= rc_n;
        tail_q <= head_n + rc_n[IW-1:0];
      end else begin
        cnt_q  <= cnt_q + CW'(alloc_go) - CW'(take);
        tail_q <= tail_q + IW'(alloc_go);
      end
    end
  end

  // per-entry written flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ok_q <= '0;
      d_ok_q <= '0;
    end else begin
      if (alloc_go) begin
        a_ok_q[tail_q] <= 1'b0;
        d_ok_q[tail_q] <= 1'b0;
      end
      if (aw_live) a_ok_q[aw_idx] <= 1'b1;
      if (dw_live) d_ok_q[dw_idx] <= 1'b1;
    end
  end

  // payload storage
  always_ff @(posedge clk) begin
    if (aw_live) addr_q[aw_idx] <= aw_addr;
    if (dw_live) data_q[dw_idx] <= dw_data;
  end

  // forwarding search: oldest to youngest, later matches win
  always_comb begin
    logic          unk, m, md;
    logic [IW-1:0] s;
    unk     = 1'b0;
    m       = 1'b0;
    md      = 1'b0;
    lk_data = '0;
    s       = '0;
    for (int i = 0; i < N; i++) begin
      s = head_q + IW'(i);
      if (CW'(i) < cnt_q) begin
        if (!a_ok_q[s]) begin
          unk = 1'b1;
        end else if (addr_q[s] == lk_addr) begin
          m       = 1'b1;
          md      = d_ok_q[s];
          lk_data = data_q[s];
        end
      end
    end
    lk_replay = unk || (m && !md);
    lk_hit    = m && !lk_replay;
  end

  // R4
  commit_after_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (rcnt_q != '0));

  // R3
  retire_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |-> (a_ok_q[rslot] && d_ok_q[rslot]));

  // R9
  flush_keeps_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_go && !retire_go && !take) |=> (cnt_q == $past(rcnt_q)));
endmodule

// File: rtl/sb_commit_arb.sv
`timescale 1ns/1ps
module sb_commit_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy0,
  input  logic rdy1,
  input  logic cm_ready,
  output logic cm_valid,
  output logic gnt,
  output logic fire
);
  logic last_q, hold_q, held_q;

  assign cm_valid = rdy0 || rdy1;
  assign fire     = cm_valid && cm_ready;

  always_comb begin
    if (hold_q)            gnt = held_q;
    else if (rdy0 && rdy1) gnt = ~last_q;
    else                   gnt = rdy1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      hold_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      if (fire) last_q <= gnt;
      hold_q <= cm_valid && !cm_ready;
      held_q <= gnt;
    end
  end

  // R10
  rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rdy0 && rdy1 && $past(fire)) |-> (gnt != $past(gnt)));
endmodule

// File: rtl/store_buffer_2t.sv
`timescale 1ns/1ps
module store_buffer_2t
  import sb_pkg::*;
#(
  parameter int N_PER_THR = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int IW       = $clog2(N_PER_THR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_tid,
  output logic              alloc_ready,
  output logic [IW-1:0]     alloc_slot,
  input  logic              aw_valid,
  input  logic              aw_tid,
  input  logic [IW-1:0]     aw_slot,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              dw_valid,
  input  logic              dw_tid,
  input  logic [IW-1:0]     dw_slot,
  input  logic [DATA_W-1:0] dw_data,
  input  logic              retire_valid,
  input  logic              retire_tid,
  input  logic              flush_valid,
  input  logic              flush_tid,
  input  logic              ld_valid,
  input  logic              ld_tid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic              ld_replay,
  output logic [DATA_W-1:0] ld_data,
  output logic              cm_valid,
  input  logic              cm_ready,
  output logic              cm_tid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data
);
  logic              full_w   [NUM_THR];
  logic [IW-1:0]     tail_w   [NUM_THR];
  logic              hrdy_w   [NUM_THR];
  logic [ADDR_W-1:0] haddr_w  [NUM_THR];
  logic [DATA_W-1:0] hdata_w  [NUM_THR];
  logic              hit_w    [NUM_THR];
  logic              rep_w    [NUM_THR];
  logic [DATA_W-1:0] fwd_w    [NUM_THR];
  logic              gnt, fire;
  thr_t              atid;

  assign atid        = thr_t'(alloc_tid);
  assign alloc_ready = !full_w[atid] && !(flush_valid && flush_tid == alloc_tid);
  assign alloc_slot  = tail_w[atid];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic me_alloc, me_aw, me_dw, me_ret, me_fl, me_take;
    assign me_alloc = alloc_valid && alloc_ready && (alloc_tid == 1'(t));
    assign me_aw    = aw_valid && (aw_tid == 1'(t));
    assign me_dw    = dw_valid && (dw_tid == 1'(t));
    assign me_ret   = retire_valid && (retire_tid == 1'(t));
    assign me_fl    = flush_valid && (flush_tid == 1'(t));
    assign me_take  = fire && (gnt == 1'(t));

    sb_thread_part #(
      .N      (N_PER_THR),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_part (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_go  (me_alloc),
      .aw_go     (me_aw),
      .aw_idx    (aw_slot),
      .aw_addr   (aw_addr),
      .dw_go     (me_dw),
      .dw_idx    (dw_slot),
      .dw_data   (dw_data),
      .retire_go (me_ret),
      .flush_go  (me_fl),
      .take      (me_take),
      .lk_addr   (ld_addr),
      .full      (full_w[t]),
      .tail_idx  (tail_w[t]),
      .head_rdy  (hrdy_w[t]),
      .head_addr (haddr_w[t]),
      .head_data (hdata_w[t]),
      .lk_hit    (hit_w[t]),
      .lk_replay (rep_w[t]),
      .lk_data   (fwd_w[t])
    );
  end

  sb_commit_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy0     (hrdy_w[0]),
    .rdy1     (hrdy_w[1]),
    .cm_ready (cm_ready),
    .cm_valid (cm_valid),
    .gnt      (gnt),
    .fire     (fire)
  );

  assign cm_tid  = gnt;
  assign cm_addr = haddr_w[thr_t'(gnt)];
  assign cm_data = hdata_w[thr_t'(gnt)];

  assign ld_hit    = ld_valid && hit_w[thr_t'(ld_tid)];
  assign ld_replay = ld_valid && rep_w[thr_t'(ld_tid)];
  assign ld_data   = ld_hit ? fwd_w[thr_t'(ld_tid)] : '0;

  // R11
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_tid) &&
                                 $stable(cm_addr) && $stable(cm_data)));

  // R8
  hit_excludes_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !(ld_hit && ld_replay));
endmodule

// File: tb/sim_store_buffer_2t.sv
`timescale 1ns/1ps
module sim_store_buffer_2t;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid = 0, alloc_tid = 0, alloc_ready;
  logic [IW-1:0] alloc_slot;
  logic aw_valid = 0, aw_tid = 0;
  logic [IW-1:0] aw_slot = '0;
  logic [AW-1:0] aw_addr = '0;
  logic dw_valid = 0, dw_tid = 0;
  logic [IW-1:0] dw_slot = '0;
  logic [DW-1:0] dw_data = '0;
  logic retire_valid = 0, retire_tid = 0;
  logic flush_valid = 0, flush_tid = 0;
  logic ld_valid = 0, ld_tid = 0;
  logic [AW-1:0] ld_addr = '0;
  logic ld_hit, ld_replay;
  logic [DW-1:0] ld_data;
  logic cm_valid, cm_ready = 0, cm_tid;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW+DW:0] exp_q [$];

  always #2 clk = ~clk;

  store_buffer_2t #(.N_PER_THR(N), .ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_alloc(input logic tid, input logic [IW-1:0] exp_slot);
    alloc_valid = 1; alloc_tid = tid;
    @(negedge clk);
    check("R2 alloc_ready", 64'(alloc_ready), 64'(1));
    check("R13 alloc_slot", 64'(alloc_slot), 64'(exp_slot));
    tick(); alloc_valid = 0;
  endtask

  task automatic probe_ready(input logic tid, input logic exp, input string tag);
    alloc_tid = tid;
    @(negedge clk);
    check(tag, 64'(alloc_ready), 64'(exp));
    tick();
  endtask

  task automatic do_aw(input logic tid, input logic [IW-1:0] s, input logic [AW-1:0] a);
    aw_valid = 1; aw_tid = tid; aw_slot = s; aw_addr = a;
    tick(); aw_valid = 0;
  endtask

  task automatic do_dw(input logic tid, input logic [IW-1:0] s, input logic [DW-1:0] d);
    dw_valid = 1; dw_tid = tid; dw_slot = s; dw_data = d;
    tick(); dw_valid = 0;
  endtask

  task automatic do_ret_fl(input logic tid, input logic r, input logic f);
    retire_valid = r; retire_tid = tid; flush_valid = f; flush_tid = tid;
    tick(); retire_valid = 0; flush_valid = 0;
  endtask

  task automatic look(input logic tid, input logic [AW-1:0] a, input logic eh,
                      input logic er, input logic [DW-1:0] ed, input string tag);
    ld_valid = 1; ld_tid = tid; ld_addr = a;
    @(negedge clk);
    check({tag, " hit"}, 64'(ld_hit), 64'(eh));
    check({tag, " replay"}, 64'(ld_replay), 64'(er));
    if (eh) check({tag, " data"}, 64'(ld_data), 64'(ed));
    tick(); ld_valid = 0;
  endtask

  task automatic expect_commit(input logic tid, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({tid, a, d});
  endtask

  // scoreboard monitor: every accepted commit must match the queue front (R5)
  always @(negedge clk) begin
    if (rst_n && cm_valid && cm_ready) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected commit", 64'({cm_tid, cm_addr, cm_data}), 64'(0));
      end else begin
        check("R5 commit order", 64'({cm_tid, cm_addr, cm_data}), 64'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW+DW:0] snap;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1 reset state
    @(negedge clk);
    check("R1 cm_valid", 64'(cm_valid), 64'(0));
    tick();
    probe_ready(0, 1, "R1 ready t0");
    probe_ready(1, 1, "R1 ready t1");
    look(0, 16'h0100, 0, 0, 0, "R1 lookup");

    // fill thread 0
    for (int i = 0; i < N; i++) do_alloc(0, IW'(i));
    probe_ready(0, 0, "R2 t0 full");
    probe_ready(1, 1, "R2 t1 open");

    // R3 data before address on slot 0, address first elsewhere
    do_dw(0, 0, 32'hA0); do_aw(0, 0, 16'h0100);
    do_aw(0, 1, 16'h0200); do_dw(0, 1, 32'hB1);
    do_aw(0, 2, 16'h0100); do_dw(0, 2, 32'hC2);
    look(0, 16'h0100, 0, 1, 0, "R8 unknown addr");
    do_aw(0, 3, 16'h0300);
    look(0, 16'h0100, 1, 0, 32'hC2, "R6 youngest");
    look(0, 16'h0200, 1, 0, 32'hB1, "R6 single");
    look(0, 16'h0300, 0, 1, 0, "R8 no data");
    look(0, 16'h0400, 0, 0, 0, "R6 miss");
    look(1, 16'h0100, 0, 0, 0, "R7 other thread");
    do_dw(0, 3, 32'hD3);

    // thread 1
    do_alloc(1, 0); do_alloc(1, 1);
    do_aw(1, 0, 16'h0100); do_dw(1, 0, 32'h11);
    do_aw(1, 1, 16'h0500); do_dw(1, 1, 32'h15);
    look(1, 16'h0100, 1, 0, 32'h11, "R7 own value");
    look(0, 16'h0500, 0, 0, 0, "R7 no cross");
    @(negedge clk);
    check("R4 nothing retired", 64'(cm_valid), 64'(0));
    tick();

    // retire, stall the port
    do_ret_fl(0, 1, 0); expect_commit(0, 16'h0100, 32'hA0);
    do_ret_fl(1, 1, 0); expect_commit(1, 16'h0100, 32'h11);
    do_ret_fl(0, 1, 0); expect_commit(0, 16'h0200, 32'hB1);
    @(negedge clk);
    check("R10 first grant", 64'(cm_tid), 64'(0));
    snap = {cm_tid, cm_addr, cm_data};
    tick();
    @(negedge clk);
    check("R11 held payload", 64'({cm_tid, cm_addr, cm_data}), 64'(snap));
    tick();

    // R12 retire and flush together on thread 0; R9 flush thread 1
    do_ret_fl(0, 1, 1); expect_commit(0, 16'h0100, 32'hC2);
    do_ret_fl(1, 0, 1);
    look(0, 16'h0300, 0, 0, 0, "R12 dropped store");
    look(1, 16'h0500, 0, 0, 0, "R9 flushed store");
    look(0, 16'h0100, 1, 0, 32'hC2, "R9 retired kept");

    cm_ready = 1;
    repeat (8) tick();
    check("R5 drained", 64'(exp_q.size()), 64'(0));
    @(negedge clk);
    check("R5 idle port", 64'(cm_valid), 64'(0));
    tick();

    // R11 grant lock and R10 alternation
    cm_ready = 0;
    do_alloc(0, 3); do_alloc(0, 0);
    do_alloc(1, 1); do_alloc(1, 2);
    do_aw(0, 3, 16'h0600); do_dw(0, 3, 32'h66);
    do_aw(0, 0, 16'h0610); do_dw(0, 0, 32'h67);
    do_aw(1, 1, 16'h0700); do_dw(1, 1, 32'h77);
    do_aw(1, 2, 16'h0710); do_dw(1, 2, 32'h78);
    do_ret_fl(0, 1, 0);
    @(negedge clk);
    check("R11 offer t0", 64'(cm_tid), 64'(0));
    tick();
    do_ret_fl(1, 1, 0);
    @(negedge clk);
    check("R11 grant locked", 64'(cm_tid), 64'(0));
    tick();
    do_ret_fl(0, 1, 0);
    do_ret_fl(1, 1, 0);
    expect_commit(0, 16'h0600, 32'h66);
    expect_commit(1, 16'h0700, 32'h77);
    expect_commit(0, 16'h0610, 32'h67);
    expect_commit(1, 16'h0710, 32'h78);
    cm_ready = 1;
    repeat (8) tick();
    check("R10 drained", 64'(exp_q.size()), 64'(0));
    probe_ready(0, 1, "R5 freed t0");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule